// File: doc/BRIEF.md
# Chip-Addressed Serial Command Receiver

This block takes commands from a host over a three-wire serial link: a data line, a serial clock and a chip-enable line. All three are asynchronous to the system clock. They are synchronized, and the block samples one data bit on every rising edge of the serial clock while chip enable is high. The falling edge of chip enable ends the frame. The block then checks the frame and issues at most one decoded command.

A frame starts with an 8-bit device address and continues with an instruction word. Both travel least significant bit first. A 24-bit instruction is used for display-control commands and for character and auxiliary memory writes. A 56-bit instruction is used for the 35-dot pattern write. Each decoded command appears as a one-cycle strobe plus field buses. A field bus holds its value until the next accepted command of the same kind.

A busy flag covers the execution time of each command. Frames that end while the flag is high are dropped. The memories and the display scan that consume these commands sit outside this block.

Top module: `ser_cmd_rx`

## Requirements
- R1: After reset every strobe, every field bus and `busy_o` are zero.
- R2: Bits are captured only on a rising serial clock while chip enable is high. Frame bit i (counting from 0) is the i-th captured bit. Bits 0..7 form the device address, and bit i of the address is frame bit i. A frame is accepted only if that address equals `DEV_ADDR`, which defaults to 8'h67 (arrival order 1,1,1,0,0,1,1,0). Frame bit 8+k is instruction bit Dk. Serial clock edges while chip enable is low change nothing.
- R3: A frame is committed when chip enable falls. If the raw chip enable is first sampled low at system edge k, the command strobe is high for exactly the cycle between edges k+2 and k+3.
- R4: A frame is accepted only with exactly 32 bits and an opcode other than 1000, or with exactly 64 bits and opcode D55..D52 = 1000. Any other count, or a mismatch between opcode and length, drops the frame.
- R5: For 32-bit frames D23..D20 selects the command: 0001 on/off, 0010 shift, 0011 digit count, 0100 base load, 0101 intensity, 0110 character write, 0111 auxiliary write. Codes 1010 and 1011 select blink. All other codes are dropped. At most one strobe is high in any cycle.
- R6: On/off fields: main at D18, aux at D17, on at D16, digit mask at D15..D0.
- R7: Blink fields: main at D20, aux at D19, rate code at D18..D16, digit mask at D15..D0.
- R8: Shift fields: main at D18, aux at D17, left at D16 (1 = left, 0 = right).
- R9: The digit count is taken from D19..D16. The intensity duty is taken from D15..D8. For a base load, the auxiliary base is D19..D16 and the character base is D13..D8.
- R10: A character write takes its address from D13..D8 and its data from D7..D0. An auxiliary write takes its address from D19..D16 and its data from D15..D8.
- R11: A pattern write takes its address from D47..D40 and its 35 dot bits from D34..D0.
- R12: `busy_o` rises with the strobe of every accepted command except base load and intensity, and stays high for exactly `BUSY_CYCLES` cycles. Base load and intensity leave it low.
- R13: A frame committed while `busy_o` is high is dropped.
- R14: Each field bus keeps its value until an accepted command of its own kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_sel_i | input | 1 | Chip enable, high during a frame |
| onoff_stb_o | output | 1 | On/off command strobe |
| onoff_main_o | output | 1 | On/off: matrix data selected |
| onoff_aux_o | output | 1 | On/off: auxiliary data selected |
| onoff_on_o | output | 1 | On/off: display on |
| onoff_mask_o | output | 16 | On/off digit mask |
| blink_stb_o | output | 1 | Blink command strobe |
| blink_main_o | output | 1 | Blink: matrix data selected |
| blink_aux_o | output | 1 | Blink: auxiliary data selected |
| blink_rate_o | output | 3 | Blink period code |
| blink_mask_o | output | 16 | Blink digit mask |
| shift_stb_o | output | 1 | Shift command strobe |
| shift_main_o | output | 1 | Shift: matrix data selected |
| shift_aux_o | output | 1 | Shift: auxiliary data selected |
| shift_left_o | output | 1 | Shift direction, 1 = left |
| digits_stb_o | output | 1 | Digit count strobe |
| digits_o | output | 4 | Digit count code |
| base_stb_o | output | 1 | Base address load strobe |
| base_aux_o | output | 4 | Auxiliary memory base |
| base_chr_o | output | 6 | Character memory base |
| duty_stb_o | output | 1 | Intensity strobe |
| duty_o | output | 8 | Intensity duty value |
| chr_wr_o | output | 1 | Character memory write strobe |
| chr_addr_o | output | 6 | Character memory address |
| chr_data_o | output | 8 | Character code |
| aux_wr_o | output | 1 | Auxiliary memory write strobe |
| aux_addr_o | output | 4 | Auxiliary memory address |
| aux_data_o | output | 8 | Auxiliary dot data |
| pat_wr_o | output | 1 | Pattern memory write strobe |
| pat_addr_o | output | 8 | Pattern memory address |
| pat_data_o | output | 35 | Pattern dot bits |
| busy_o | output | 1 | Command execution in progress |

## Verification
Some properties are checked on every cycle:
- at most one strobe is high, and each strobe lasts one cycle;
- a field bus stays still while its strobe is low;
- the bit counter clears while chip enable is low and never passes its saturation value;
- `busy_o` follows every busy-class strobe, and a commit that arrives during busy produces no strobe.

Other behaviour only the bench's scenarios can show, by comparing against a behavioural model on every clock:
- the exact field bit positions;
- the address match;
- the accepted frame lengths and the opcode and length pairing;
- the two-edge commit latency and the exact busy length.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int ADDR_W   = 8;
    localparam int SHORT_W  = 24;
    localparam int LONG_W   = 56;
    localparam int SHORT_TOT = ADDR_W + SHORT_W;
    localparam int LONG_TOT  = ADDR_W + LONG_W;
    localparam int CNT_W    = $clog2(LONG_TOT + 2);
    localparam int IDX_W    = $clog2(LONG_W);
    localparam int AIDX_W   = $clog2(ADDR_W);

    localparam int MASK_W   = 16;
    localparam int RATE_W   = 3;
    localparam int DIG_W    = 4;
    localparam int ABASE_W  = 4;
    localparam int CBASE_W  = 6;
    localparam int DUTY_W   = 8;
    localparam int CHR_A_W  = 6;
    localparam int CHR_D_W  = 8;
    localparam int AUX_A_W  = 4;
    localparam int AUX_D_W  = 8;
    localparam int PAT_A_W  = 8;
    localparam int PAT_D_W  = 35;
    localparam int NUM_STB  = 9;

    localparam logic [3:0] OPC_PAT = 4'b1000;

    typedef enum logic [3:0] {
        K_NONE, K_ONOFF, K_BLINK, K_SHIFT, K_DIGITS,
        K_BASE, K_DUTY, K_CHR, K_AUX, K_PAT
    } cmd_kind_e;

    typedef struct packed {
        logic                 onoff_stb;
        logic                 onoff_main;
        logic                 onoff_aux;
        logic                 onoff_on;
        logic [MASK_W-1:0]    onoff_mask;
        logic                 blink_stb;
        logic                 blink_main;
        logic                 blink_aux;
        logic [RATE_W-1:0]    blink_rate;
        logic [MASK_W-1:0]    blink_mask;
        logic                 shift_stb;
        logic                 shift_main;
        logic                 shift_aux;
        logic                 shift_left;
        logic                 digits_stb;
        logic [DIG_W-1:0]     digits;
        logic                 base_stb;
        logic [ABASE_W-1:0]   base_aux;
        logic [CBASE_W-1:0]   base_chr;
        logic                 duty_stb;
        logic [DUTY_W-1:0]    duty;
        logic                 chr_wr;
        logic [CHR_A_W-1:0]   chr_addr;
        logic [CHR_D_W-1:0]   chr_data;
        logic                 aux_wr;
        logic [AUX_A_W-1:0]   aux_addr;
        logic [AUX_D_W-1:0]   aux_data;
        logic                 pat_wr;
        logic [PAT_A_W-1:0]   pat_addr;
        logic [PAT_D_W-1:0]   pat_data;
    } cmd_out_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] lvl_o,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);

    typedef struct packed {
        logic [LANES-1:0] meta;
        logic [LANES-1:0] stab;
        logic [LANES-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_i;
        s_d.stab = s_q.meta;
        s_d.prev = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lvl_o[g]  = s_q.stab[g];
        assign rise_o[g] = s_q.stab[g] & ~s_q.prev[g];
        assign fall_o[g] = ~s_q.stab[g] & s_q.prev[g];
    end

    // R3: an edge is reported for a single cycle only
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_rise_i,
    input  logic              dat_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LONG_W-1:0] instr_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(LONG_TOT + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LONG_W-1:0] instr;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t r_d, r_q;
    logic [IDX_W-1:0]  ins_idx;
    logic [AIDX_W-1:0] adr_idx;

    always_comb begin
        ins_idx = IDX_W'(r_q.cnt - CNT_W'(ADDR_W));
        adr_idx = AIDX_W'(r_q.cnt);
        r_d     = r_q;
        if (!sel_i) begin
            r_d.cnt = '0;
        end else if (sclk_rise_i && (r_q.cnt != SAT)) begin
            if (r_q.cnt < CNT_W'(ADDR_W)) r_d.addr[adr_idx] = dat_i;
            else if (r_q.cnt < CNT_W'(LONG_TOT)) r_d.instr[ins_idx] = dat_i;
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_o  = r_q.addr;
    assign instr_o = r_q.instr;
    assign count_o = r_q.cnt;

    // R2: the bit counter restarts whenever chip enable is low
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (count_o == '0));
    // R4: an overlong frame parks at the saturation value
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= SAT);

endmodule

// File: rtl/srx_busy.sv
module srx_busy #(
    parameter int BUSY_CYCLES = 3600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } bsy_t;

    bsy_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load_i)              b_d.cnt = BW'(BUSY_CYCLES);
        else if (b_q.cnt != '0)  b_d.cnt = b_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign busy_o = (b_q.cnt != '0);

    // R12: a load always raises busy on the next cycle
    p_busy_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
    // R12: without a load the remaining time only counts down
    p_busy_down_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load_i) |=> (b_q.cnt < $past(b_q.cnt)));

endmodule

// File: rtl/srx_decode.sv
module srx_decode
    import srx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h67
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LONG_W-1:0] instr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              load_busy_o,
    output cmd_out_t          out_o
);

    cmd_out_t  o_d, o_q;
    cmd_kind_e kind;
    logic      accept;
    logic      unused_bits;

    assign unused_bits = ^{instr_i[51:48], instr_i[39:35]};

    always_comb begin
        kind = K_NONE;
        if (count_i == CNT_W'(LONG_TOT)) begin
            if (instr_i[55:52] == OPC_PAT) kind = K_PAT;
        end else if (count_i == CNT_W'(SHORT_TOT)) begin
            if (instr_i[23:21] == 3'b101) begin
                kind = K_BLINK;
            end else begin
                case (instr_i[23:20])
                    4'b0001: kind = K_ONOFF;
                    4'b0010: kind = K_SHIFT;
                    4'b0011: kind = K_DIGITS;
                    4'b0100: kind = K_BASE;
                    4'b0101: kind = K_DUTY;
                    4'b0110: kind = K_CHR;
                    4'b0111: kind = K_AUX;
                    default: kind = K_NONE;
                endcase
            end
        end
    end

    assign accept      = commit_i && !busy_i && (addr_i == DEV_ADDR) && (kind != K_NONE);
    assign load_busy_o = accept && (kind != K_BASE) && (kind != K_DUTY);

    always_comb begin
        o_d            = o_q;
        o_d.onoff_stb  = 1'b0;
        o_d.blink_stb  = 1'b0;
        o_d.shift_stb  = 1'b0;
        o_d.digits_stb = 1'b0;
        o_d.base_stb   = 1'b0;
        o_d.duty_stb   = 1'b0;
        o_d.chr_wr     = 1'b0;
        o_d.aux_wr     = 1'b0;
        o_d.pat_wr     = 1'b0;
        if (accept) begin
            case (kind)
                K_ONOFF: begin
                    o_d.onoff_stb  = 1'b1;
                    o_d.onoff_main = instr_i[18];
                    o_d.onoff_aux  = instr_i[17];
                    o_d.onoff_on   = instr_i[16];
                    o_d.onoff_mask = instr_i[15:0];
                end
                K_BLINK: begin
                    o_d.blink_stb  = 1'b1;
                    o_d.blink_main = instr_i[20];
                    o_d.blink_aux  = instr_i[19];
                    o_d.blink_rate = instr_i[18:16];
                    o_d.blink_mask = instr_i[15:0];
                end
                K_SHIFT: begin
                    o_d.shift_stb  = 1'b1;
                    o_d.shift_main = instr_i[18];
                    o_d.shift_aux  = instr_i[17];
                    o_d.shift_left = instr_i[16];
                end
                K_DIGITS: begin
                    o_d.digits_stb = 1'b1;
                    o_d.digits     = instr_i[19:16];
                end
                K_BASE: begin
                    o_d.base_stb = 1'b1;
                    o_d.base_aux = instr_i[19:16];
                    o_d.base_chr = instr_i[13:8];
                end
                K_DUTY: begin
                    o_d.duty_stb = 1'b1;
                    o_d.duty     = instr_i[15:8];
                end
                K_CHR: begin
                    o_d.chr_wr   = 1'b1;
                    o_d.chr_addr = instr_i[13:8];
                    o_d.chr_data = instr_i[7:0];
                end
                K_AUX: begin
                    o_d.aux_wr   = 1'b1;
                    o_d.aux_addr = instr_i[19:16];
                    o_d.aux_data = instr_i[15:8];
                end
                K_PAT: begin
                    o_d.pat_wr   = 1'b1;
                    o_d.pat_addr = instr_i[47:40];
                    o_d.pat_data = instr_i[34:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_o = o_q;

    logic [NUM_STB-1:0] stb_vec;
    assign stb_vec = {o_q.onoff_stb, o_q.blink_stb, o_q.shift_stb, o_q.digits_stb,
                      o_q.base_stb, o_q.duty_stb, o_q.chr_wr, o_q.aux_wr, o_q.pat_wr};

    // R5: one command at a time
    p_onehot_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_vec));
    // R13: a commit during busy yields no strobe
    p_drop_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && busy_i) |=> (stb_vec == '0));
    // R14: fields hold between their own strobes
    p_hold_onoff_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.onoff_stb |-> $stable(o_q.onoff_mask));
    p_hold_pat_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.pat_wr |-> $stable(o_q.pat_data));

endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx
    import srx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h67,
    parameter int                BUSY_CYCLES = 3600
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_dat_i,
    input  logic                ser_clk_i,
    input  logic                ser_sel_i,
    output logic                onoff_stb_o,
    output logic                onoff_main_o,
    output logic                onoff_aux_o,
    output logic                onoff_on_o,
    output logic [MASK_W-1:0]   onoff_mask_o,
    output logic                blink_stb_o,
    output logic                blink_main_o,
    output logic                blink_aux_o,
    output logic [RATE_W-1:0]   blink_rate_o,
    output logic [MASK_W-1:0]   blink_mask_o,
    output logic                shift_stb_o,
    output logic                shift_main_o,
    output logic                shift_aux_o,
    output logic                shift_left_o,
    output logic                digits_stb_o,
    output logic [DIG_W-1:0]    digits_o,
    output logic                base_stb_o,
    output logic [ABASE_W-1:0]  base_aux_o,
    output logic [CBASE_W-1:0]  base_chr_o,
    output logic                duty_stb_o,
    output logic [DUTY_W-1:0]   duty_o,
    output logic                chr_wr_o,
    output logic [CHR_A_W-1:0]  chr_addr_o,
    output logic [CHR_D_W-1:0]  chr_data_o,
    output logic                aux_wr_o,
    output logic [AUX_A_W-1:0]  aux_addr_o,
    output logic [AUX_D_W-1:0]  aux_data_o,
    output logic                pat_wr_o,
    output logic [PAT_A_W-1:0]  pat_addr_o,
    output logic [PAT_D_W-1:0]  pat_data_o,
    output logic                busy_o
);

    localparam int LANES    = 3;
    localparam int LANE_DAT = 0;
    localparam int LANE_CLK = 1;
    localparam int LANE_SEL = 2;

    logic [LANES-1:0]  lvl, rise, fall;
    logic [ADDR_W-1:0] f_addr;
    logic [LONG_W-1:0] f_instr;
    logic [CNT_W-1:0]  f_cnt;
    logic              load_busy;
    cmd_out_t          cmd;
    logic              unused_edges;

    assign unused_edges = ^{rise[LANE_DAT], rise[LANE_SEL], fall[LANE_DAT], fall[LANE_CLK], lvl[LANE_CLK]};

    srx_sync #(.LANES(LANES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({ser_sel_i, ser_clk_i, ser_dat_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    srx_shifter u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (lvl[LANE_SEL]),
        .sclk_rise_i (rise[LANE_CLK]),
        .dat_i       (lvl[LANE_DAT]),
        .addr_o      (f_addr),
        .instr_o     (f_instr),
        .count_o     (f_cnt)
    );

    srx_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (fall[LANE_SEL]),
        .busy_i      (busy_o),
        .addr_i      (f_addr),
        .instr_i     (f_instr),
        .count_i     (f_cnt),
        .load_busy_o (load_busy),
        .out_o       (cmd)
    );

    srx_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_busy),
        .busy_o (busy_o)
    );

    assign onoff_stb_o  = cmd.onoff_stb;
    assign onoff_main_o = cmd.onoff_main;
    assign onoff_aux_o  = cmd.onoff_aux;
    assign onoff_on_o   = cmd.onoff_on;
    assign onoff_mask_o = cmd.onoff_mask;
    assign blink_stb_o  = cmd.blink_stb;
    assign blink_main_o = cmd.blink_main;
    assign blink_aux_o  = cmd.blink_aux;
    assign blink_rate_o = cmd.blink_rate;
    assign blink_mask_o = cmd.blink_mask;
    assign shift_stb_o  = cmd.shift_stb;
    assign shift_main_o = cmd.shift_main;
    assign shift_aux_o  = cmd.shift_aux;
    assign shift_left_o = cmd.shift_left;
    assign digits_stb_o = cmd.digits_stb;
    assign digits_o     = cmd.digits;
    assign base_stb_o   = cmd.base_stb;
    assign base_aux_o   = cmd.base_aux;
    assign base_chr_o   = cmd.base_chr;
    assign duty_stb_o   = cmd.duty_stb;
    assign duty_o       = cmd.duty;
    assign chr_wr_o     = cmd.chr_wr;
    assign chr_addr_o   = cmd.chr_addr;
    assign chr_data_o   = cmd.chr_data;
    assign aux_wr_o     = cmd.aux_wr;
    assign aux_addr_o   = cmd.aux_addr;
    assign aux_data_o   = cmd.aux_data;
    assign pat_wr_o     = cmd.pat_wr;
    assign pat_addr_o   = cmd.pat_addr;
    assign pat_data_o   = cmd.pat_data;

    logic any_stb;
    assign any_stb = onoff_stb_o | blink_stb_o | shift_stb_o | digits_stb_o | base_stb_o |
                     duty_stb_o | chr_wr_o | aux_wr_o | pat_wr_o;

    // R3: every command strobe is a single-cycle pulse
    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);
    // R12: a writing command is always covered by busy
    p_busy_cover_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_wr_o || aux_wr_o || pat_wr_o || onoff_stb_o) |-> busy_o);

endmodule

// File: tb/sim_ser_cmd_rx.sv
module sim_ser_cmd_rx;

    localparam int BUSY = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_dat = 1'b0, raw_clk = 1'b0, raw_sel = 1'b0;

    always #2.5 clk = ~clk;

    logic onoff_stb, onoff_main, onoff_aux, onoff_on;
    logic [15:0] onoff_mask;
    logic blink_stb, blink_main, blink_aux;
    logic [2:0] blink_rate;
    logic [15:0] blink_mask;
    logic shift_stb, shift_main, shift_aux, shift_left;
    logic digits_stb; logic [3:0] digits;
    logic base_stb; logic [3:0] base_aux; logic [5:0] base_chr;
    logic duty_stb; logic [7:0] duty;
    logic chr_wr; logic [5:0] chr_addr; logic [7:0] chr_data;
    logic aux_wr; logic [3:0] aux_addr; logic [7:0] aux_data;
    logic pat_wr; logic [7:0] pat_addr; logic [34:0] pat_data;
    logic busy;

    ser_cmd_rx #(.DEV_ADDR(8'h67), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ser_dat_i(raw_dat), .ser_clk_i(raw_clk), .ser_sel_i(raw_sel),
        .onoff_stb_o(onoff_stb), .onoff_main_o(onoff_main), .onoff_aux_o(onoff_aux),
        .onoff_on_o(onoff_on), .onoff_mask_o(onoff_mask),
        .blink_stb_o(blink_stb), .blink_main_o(blink_main), .blink_aux_o(blink_aux),
        .blink_rate_o(blink_rate), .blink_mask_o(blink_mask),
        .shift_stb_o(shift_stb), .shift_main_o(shift_main), .shift_aux_o(shift_aux),
        .shift_left_o(shift_left),
        .digits_stb_o(digits_stb), .digits_o(digits),
        .base_stb_o(base_stb), .base_aux_o(base_aux), .base_chr_o(base_chr),
        .duty_stb_o(duty_stb), .duty_o(duty),
        .chr_wr_o(chr_wr), .chr_addr_o(chr_addr), .chr_data_o(chr_data),
        .aux_wr_o(aux_wr), .aux_addr_o(aux_addr), .aux_data_o(aux_data),
        .pat_wr_o(pat_wr), .pat_addr_o(pat_addr), .pat_data_o(pat_data),
        .busy_o(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    int seen = 0;
    int want = 0;
    bit done = 0;
    bit cmp_on = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0] h1, h2, h3;
    bit mq[$];
    int bcnt;
    logic [8:0] e_stb;  // onoff blink shift digits base duty chr aux pat
    logic e_om, e_oa, e_oo; logic [15:0] e_omask;
    logic e_bm, e_ba; logic [2:0] e_brate; logic [15:0] e_bmask;
    logic e_sm, e_sa, e_sl;
    logic [3:0] e_dig; logic [3:0] e_baux; logic [5:0] e_bchr; logic [7:0] e_duty;
    logic [5:0] e_ca; logic [7:0] e_cd; logic [3:0] e_aa; logic [7:0] e_ad;
    logic [7:0] e_pa; logic [34:0] e_pd;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0; h3 = '0; mq.delete(); bcnt = 0; e_stb = '0;
            {e_om, e_oa, e_oo, e_omask} = '0; {e_bm, e_ba, e_brate, e_bmask} = '0;
            {e_sm, e_sa, e_sl} = '0; e_dig = '0; e_baux = '0; e_bchr = '0; e_duty = '0;
            e_ca = '0; e_cd = '0; e_aa = '0; e_ad = '0; e_pa = '0; e_pd = '0;
        end else begin
            bit was_busy;
            e_stb = '0;
            was_busy = (bcnt != 0);
            if (bcnt != 0) bcnt--;
            if (h3[2] && !h2[2]) begin
                int n;
                logic [7:0] adr;
                logic [55:0] ins;
                n = mq.size();
                adr = '0; ins = '0;
                for (int i = 0; i < n && i < 64; i++) begin
                    if (i < 8) adr[i] = mq[i];
                    else ins[i-8] = mq[i];
                end
                if (adr == 8'h67 && !was_busy) begin
                    int k;
                    k = -1;
                    if (n == 64 && ins[55:52] == 4'd8) k = 8;
                    else if (n == 32) begin
                        if (ins[23:21] == 3'b101) k = 1;
                        else if (ins[23:20] == 4'd1) k = 0;
                        else if (ins[23:20] == 4'd2) k = 2;
                        else if (ins[23:20] == 4'd3) k = 3;
                        else if (ins[23:20] == 4'd4) k = 4;
                        else if (ins[23:20] == 4'd5) k = 5;
                        else if (ins[23:20] == 4'd6) k = 6;
                        else if (ins[23:20] == 4'd7) k = 7;
                    end
                    if (k >= 0) begin
                        e_stb[8-k] = 1'b1;
                        if (k != 4 && k != 5) bcnt = BUSY;
                        case (k)
                            0: begin e_om = ins[18]; e_oa = ins[17]; e_oo = ins[16]; e_omask = ins[15:0]; end
                            1: begin e_bm = ins[20]; e_ba = ins[19]; e_brate = ins[18:16]; e_bmask = ins[15:0]; end
                            2: begin e_sm = ins[18]; e_sa = ins[17]; e_sl = ins[16]; end
                            3: e_dig = ins[19:16];
                            4: begin e_baux = ins[19:16]; e_bchr = ins[13:8]; end
                            5: e_duty = ins[15:8];
                            6: begin e_ca = ins[13:8]; e_cd = ins[7:0]; end
                            7: begin e_aa = ins[19:16]; e_ad = ins[15:8]; end
                            default: begin e_pa = ins[47:40]; e_pd = ins[34:0]; end
                        endcase
                    end
                end
            end
            if (!h2[2]) mq.delete();
            else if (h2[1] && !h3[1]) mq.push_back(h2[0]);
            h3 = h2; h2 = h1; h1 = {raw_sel, raw_clk, raw_dat};
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (onoff_stb | blink_stb | shift_stb | digits_stb | base_stb | duty_stb | chr_wr | aux_wr | pat_wr)
            seen++;
        if (cmp_on && rst_n) begin
            check("R3 R5 strobes", {55'd0, onoff_stb, blink_stb, shift_stb, digits_stb, base_stb,
                  duty_stb, chr_wr, aux_wr, pat_wr}, {55'd0, e_stb});
            check("R6 onoff fields", {45'd0, onoff_main, onoff_aux, onoff_on, onoff_mask},
                  {45'd0, e_om, e_oa, e_oo, e_omask});
            check("R7 blink fields", {43'd0, blink_main, blink_aux, blink_rate, blink_mask},
                  {43'd0, e_bm, e_ba, e_brate, e_bmask});
            check("R8 shift fields", {61'd0, shift_main, shift_aux, shift_left}, {61'd0, e_sm, e_sa, e_sl});
            check("R9 digits base duty", {42'd0, digits, base_aux, base_chr, duty},
                  {42'd0, e_dig, e_baux, e_bchr, e_duty});
            check("R10 chr aux writes", {38'd0, chr_addr, chr_data, aux_addr, aux_data},
                  {38'd0, e_ca, e_cd, e_aa, e_ad});
            check("R11 pattern write", {21'd0, pat_addr, pat_data}, {21'd0, e_pa, e_pd});
            check("R12 busy", {63'd0, busy}, {63'd0, (bcnt != 0)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] adr, input logic [55:0] ins, input int nbits, input int hp);
        @(negedge clk);
        raw_sel = 1'b1;
        wait_clk(hp);
        for (int i = 0; i < nbits; i++) begin
            raw_clk = 1'b0;
            raw_dat = (i < 8) ? adr[i] : ((i - 8 < 56) ? ins[i-8] : 1'b0);
            wait_clk(hp);
            raw_clk = 1'b1;
            wait_clk(hp);
        end
        raw_clk = 1'b0;
        wait_clk(hp);
        raw_sel = 1'b0;
        wait_clk(hp);
    endtask

    task automatic cmd24(input logic [23:0] ins, input bit ok, input string tag);
        send(8'h67, {32'd0, ins}, 32, 4);
        wait_clk(BUSY + 10);
        if (ok) want++;
        check(tag, seen, want);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        wait_clk(5);
        // R1: reset state
        check("R1 reset strobes and busy", {onoff_stb, blink_stb, shift_stb, digits_stb, base_stb,
              duty_stb, chr_wr, aux_wr, pat_wr, busy}, 64'd0);
        check("R1 reset fields", {onoff_mask, blink_mask, pat_data[31:0]}, 64'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        wait_clk(4);

        cmd24({4'b0001, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00FF}, 1, "R6 on/off accepted");
        cmd24({3'b101, 1'b0, 1'b1, 3'd5, 16'hA5C3}, 1, "R7 blink accepted");
        cmd24({4'b0010, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0}, 1, "R8 shift accepted");
        cmd24({4'b0011, 4'd8, 16'h0}, 1, "R9 digit count accepted");
        cmd24({4'b0100, 4'hB, 2'b00, 6'h2D, 8'h0}, 1, "R9 base load accepted");
        cmd24({4'b0101, 4'h0, 8'hF0, 8'h0}, 1, "R9 intensity accepted");
        cmd24({4'b0110, 4'h0, 2'b00, 6'h3E, 8'h53}, 1, "R10 char write accepted");
        cmd24({4'b0111, 4'h9, 8'hC6, 8'h0}, 1, "R10 aux write accepted");

        // R11: 64-bit pattern write
        send(8'h67, {4'b1000, 4'h0, 8'hA7, 5'h0, 35'h5_1234_ABCD}, 64, 4);
        wait_clk(BUSY + 10);
        want++;
        check("R11 pattern write accepted", seen, want);

        // R2: wrong device address
        send(8'h66, {32'd0, 4'b0110, 4'h0, 8'h11, 8'h22}, 32, 4);
        wait_clk(BUSY + 10);
        check("R2 foreign address dropped", seen, want);

        // R4: bad lengths and opcode/length mismatches
        send(8'h67, {32'd0, 4'b0110, 4'h0, 8'h11, 8'h22}, 31, 4);
        wait_clk(BUSY + 10);
        check("R4 31-bit frame dropped", seen, want);
        send(8'h67, {32'd0, 4'b0110, 4'h0, 8'h11, 8'h22}, 33, 4);
        wait_clk(BUSY + 10);
        check("R4 33-bit frame dropped", seen, want);
        send(8'h67, {4'b1000, 52'h0_12_00_0000_1111}, 66, 4);
        wait_clk(BUSY + 10);
        check("R4 66-bit frame dropped", seen, want);
        cmd24({4'b1000, 4'h0, 8'h12, 8'h34}, 0, "R4 pattern opcode in short frame dropped");
        send(8'h67, {4'b0110, 52'h0_00_00_0001_2345}, 64, 4);
        wait_clk(BUSY + 10);
        check("R4 short opcode in long frame dropped", seen, want);

        // R5: unused opcodes
        cmd24({4'b0000, 20'hFFFFF}, 0, "R5 opcode 0000 dropped");
        cmd24({4'b1100, 20'hFFFFF}, 0, "R5 opcode 1100 dropped");

        // R2: serial clock pulses while enable is low are ignored
        for (int i = 0; i < 5; i++) begin
            raw_dat = 1'b1; raw_clk = 1'b1; wait_clk(4);
            raw_clk = 1'b0; wait_clk(4);
        end
        cmd24({4'b0110, 4'h0, 2'b00, 6'h05, 8'h41}, 1, "R2 idle clocks ignored");

        // R14: a second on/off leaves blink fields alone
        cmd24({4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1234}, 1, "R14 on/off update");
        check("R14 blink mask held", {48'd0, blink_mask}, {48'd0, 16'hA5C3});

        // R13: a frame committed during busy is dropped, a later one is not
        send(8'h67, {32'd0, 4'b0110, 4'h0, 8'h01, 8'h99}, 32, 2);
        want++;
        send(8'h67, {32'd0, 4'b0110, 4'h0, 8'h02, 8'h77}, 32, 2);
        wait_clk(BUSY + 10);
        check("R13 frame during busy dropped", seen, want);
        cmd24({4'b0110, 4'h0, 8'h02, 8'h77}, 1, "R13 frame after busy accepted");
        check("R10 char data after retry", {50'd0, chr_addr, chr_data}, {50'd0, 6'h02, 8'h77});

        wait_clk(20);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule